// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block turns one data load or store request into a physical address, an uncacheable flag, a fault code and a memory-management status vector. It sits beside a TLB: the TLB's lookup result for the request (hit, page frame number, per-mode read and write enables, fault-on-read and fault-on-write bits) arrives in the same cycle as the request. The block itself holds no page table entries.

All checks are made in one combinational pass, which gives them a fixed priority. A misaligned access faults first. The physical flag bypasses translation. An address that is not canonical is a page fault. A kernel-only superpage window maps addresses directly. A TLB miss or a permission check follows. On the final physical address the block looks for a machine check, an uncacheable access or the unimplemented register space. The result is registered and shows up one cycle after the request strobe.

Top module: `dxlate_chk`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise; outputs are zero after reset.
- R2: With access size code `sz` (0..3 meaning 1, 2, 4, 8 bytes), any set bit of `va` below the access size gives fault code 1 (alignment) ahead of every other check, with status bit 0 (write) equal to `is_store` and no other status bit.
- R3: With `phys_req` set, the physical address is `va` unchanged; the canonical, superpage, TLB and permission checks are skipped.
- R4: Without `phys_req`, a `va` whose bits 63:47 are not all equal gives fault code 3 (page fault) with status bits 5 (bad address) and 1 (access violation), plus bit 0 for stores.
- R5: A canonical `va` with bits 47:41 equal to 7'h7E is a superpage access. If `cur_mode` is not kernel (0), even in PAL code, it gives fault code 2 (access violation) with status bit 1 plus bit 0 for stores. Otherwise the address is `va[43:0]` with bits 43:40 all set when `va[40]` is 1 and all cleared when it is 0. The TLB result is ignored.
- R6: The mode used for the permission checks is `cur_mode`, except with `pal_mode` set: then it is `alt_mode` if `alt_req` is set and kernel (0) if not. `alt_req` has no effect outside PAL code.
- R7: A TLB miss gives fault code 4, or 5 when `ptab_req` is set, with status bit 4 (miss) plus bit 0 for stores.
- R8: On a hit the physical address is `tlb_ppn` shifted left by 13 plus `va[12:0]`.
- R9: A store with bit `mode` of `tlb_wr_en` clear gives fault code 3 with status bits 0 and 1, plus bit 3 (fault-on-write) when `tlb_fow` is set. A permitted store with `tlb_fow` set gives fault code 3 with status bits 0 and 3 only.
- R10: A load with bit `mode` of `tlb_rd_en` clear gives fault code 2 with status bit 1, plus bit 2 (fault-on-read) when `tlb_for` is set. A permitted load with `tlb_for` set gives fault code 3 with status bit 2 only. Status bit 0 stays clear for loads.
- R11: When no fault has been found yet and any bit 63:44 of the physical address is set, the result is fault code 6 (machine check) with a zero status vector.
- R12: When physical address bit 43 is set: if bits 43:20 are all ones, the result is fault code 7 (unimplemented space); otherwise `uncached` is 1 and bits 42:35 of `pa` are cleared.
- R13: With any fault code other than 0, `pa` is zero and `uncached` is 0. With fault code 0, `mm_stat` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| va | input | 64 | Virtual address |
| sz | input | 2 | Access size code, bytes = 1 << sz |
| is_store | input | 1 | 1 for a store, 0 for a load |
| phys_req | input | 1 | Treat va as a physical address |
| alt_req | input | 1 | Use the alternate mode while in PAL code |
| ptab_req | input | 1 | Request is a page-table access |
| cur_mode | input | 2 | Current mode, 0 = kernel |
| alt_mode | input | 2 | Alternate mode |
| pal_mode | input | 1 | Executing PAL code |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_ppn | input | PPN_W | Page frame number from the TLB |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_for | input | 1 | Fault-on-read bit |
| tlb_fow | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| pa | output | 44 | Physical address |
| uncached | output | 1 | Access is uncacheable |
| fault | output | 3 | Fault code |
| mm_stat | output | 6 | Status vector: 0 write, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad address |

## Verification
The checker watches a few things on every cycle: the response follows the strobe by one cycle, alignment faults win over every other check, a faulted result carries no address and a clean result carries no status, uncacheable results have the right address form, miss codes carry the miss status, and physical pass-through returns the address unchanged. The rest needs a chosen TLB entry and mode to show up, and the bench scenarios cover it: the PAL mode override and its alternate-mode choice, the superpage sign handling and its use of the raw current mode, the permission and fault-on bits in both directions, the machine-check and unimplemented-space boundaries, and the translated address value.

// File: rtl/dxlate_chk.sv
module dxlate_chk #(
  parameter int PPN_W = 32,
  parameter int PG_SH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      va,
  input  logic [1:0]       sz,
  input  logic             is_store,
  input  logic             phys_req,
  input  logic             alt_req,
  input  logic             ptab_req,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       alt_mode,
  input  logic             pal_mode,
  input  logic             tlb_hit,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic [3:0]       tlb_rd_en,
  input  logic [3:0]       tlb_wr_en,
  input  logic             tlb_for,
  input  logic             tlb_fow,
  output logic             rsp_valid,
  output logic [43:0]      pa,
  output logic             uncached,
  output logic [2:0]       fault,
  output logic [5:0]       mm_stat
);
  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_ALIGN = 3'd1;
  localparam logic [2:0] F_ACV   = 3'd2;
  localparam logic [2:0] F_PAGE  = 3'd3;
  localparam logic [2:0] F_MISS  = 3'd4;
  localparam logic [2:0] F_PTMIS = 3'd5;
  localparam logic [2:0] F_MCHK  = 3'd6;
  localparam logic [2:0] F_UNIMP = 3'd7;
  localparam int S_WR = 0, S_ACV = 1, S_FOR = 2, S_FOW = 3, S_MISS = 4, S_BVA = 5;

  logic [3:0]  amask;
  logic        misalign, canon, superpg, rd_ok, wr_ok;
  logic [1:0]  mode;
  logic [63:0] pa_hit, raw;
  logic [43:0] pa_n;
  logic        unc_n;
  logic [2:0]  f;
  logic [5:0]  st;

  assign amask    = 4'(4'd1 << sz) - 4'd1;
  assign misalign = |(va[3:0] & amask);
  assign canon    = (&va[63:47]) | ~(|va[63:47]);
  assign superpg  = va[47:41] == 7'h7E;
  assign mode     = !pal_mode ? cur_mode : (alt_req ? alt_mode : 2'd0);
  assign rd_ok    = tlb_rd_en[mode];
  assign wr_ok    = tlb_wr_en[mode];
  assign pa_hit   = ({{(64-PPN_W){1'b0}}, tlb_ppn} << PG_SH)
                  | {{(64-PG_SH){1'b0}}, va[PG_SH-1:0]};

  always_comb begin
    f   = F_NONE;
    st  = '0;
    raw = '0;
    if (misalign) begin
      f = F_ALIGN;
      st[S_WR] = is_store;
    end else if (phys_req) begin
      raw = va;
    end else if (!canon) begin
      f = F_PAGE;
      st[S_WR]  = is_store;
      st[S_ACV] = 1'b1;
      st[S_BVA] = 1'b1;
    end else if (superpg) begin
      if (cur_mode != 2'd0) begin
        f = F_ACV;
        st[S_WR]  = is_store;
        st[S_ACV] = 1'b1;
      end else begin
        raw = {20'd0, va[43:0]};
        raw[43:40] = va[40] ? 4'hF : 4'h0;
      end
    end else if (!tlb_hit) begin
      f = ptab_req ? F_PTMIS : F_MISS;
      st[S_WR]   = is_store;
      st[S_MISS] = 1'b1;
    end else begin
      raw = pa_hit;
      if (is_store) begin
        if (!wr_ok) begin
          f = F_PAGE;
          st[S_WR]  = 1'b1;
          st[S_ACV] = 1'b1;
          st[S_FOW] = tlb_fow;
        end else if (tlb_fow) begin
          f = F_PAGE;
          st[S_WR]  = 1'b1;
          st[S_FOW] = 1'b1;
        end
      end else begin
        if (!rd_ok) begin
          f = F_ACV;
          st[S_ACV] = 1'b1;
          st[S_FOR] = tlb_for;
        end else if (tlb_for) begin
          f = F_PAGE;
          st[S_FOR] = 1'b1;
        end
      end
    end

    pa_n  = '0;
    unc_n = 1'b0;
    if (f == F_NONE) begin
      if (|raw[63:44]) begin
        f = F_MCHK;
      end else if (raw[43]) begin
        if (&raw[43:20]) begin
          f = F_UNIMP;
        end else begin
          unc_n = 1'b1;
          pa_n  = raw[43:0];
          pa_n[42:35] = '0;
        end
      end else begin
        pa_n = raw[43:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      pa        <= '0;
      uncached  <= 1'b0;
      fault     <= F_NONE;
      mm_stat   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        pa       <= pa_n;
        uncached <= unc_n;
        fault    <= f;
        mm_stat  <= st;
      end
    end
  end
endmodule

// File: rtl/dxlate_chk_sva.sv
module dxlate_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] va,
  input logic [1:0]  sz,
  input logic        is_store,
  input logic        phys_req,
  input logic        rsp_valid,
  input logic [43:0] pa,
  input logic        uncached,
  input logic [2:0]  fault,
  input logic [5:0]  mm_stat
);
  logic odd;
  assign odd = |(va[3:0] & (4'(4'd1 << sz) - 4'd1));

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_stray_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_align_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && odd |=> fault == 3'd1 && mm_stat == {5'd0, $past(is_store)});
  p_phys_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && phys_req && !odd && va[63:43] == 21'd0
      |=> fault == 3'd0 && pa == $past(va[43:0]) && !uncached);
  p_miss_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (fault == 3'd4 || fault == 3'd5) |-> mm_stat[4] && !mm_stat[1]);
  p_uncached_form_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && uncached |-> pa[43] && pa[42:35] == 8'd0 && fault == 3'd0);
  p_fault_no_pa_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && fault != 3'd0 |-> pa == 44'd0 && !uncached);
  p_clean_no_stat_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && fault == 3'd0 |-> mm_stat == 6'd0);
endmodule

bind dxlate_chk dxlate_chk_sva u_sva (.*);

// File: tb/test_dxlate_chk.sv
module test_dxlate_chk;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [63:0] va;
  logic [1:0]  sz, cur_mode, alt_mode;
  logic is_store, phys_req, alt_req, ptab_req, pal_mode, tlb_hit, tlb_for, tlb_fow;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_rd_en, tlb_wr_en;
  logic        rsp_valid, uncached;
  logic [43:0] pa;
  logic [2:0]  fault;
  logic [5:0]  mm_stat;

  typedef struct {
    logic [43:0] pa;
    logic        unc;
    logic [2:0]  f;
    logic [5:0]  st;
    string       tag;
  } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dxlate_chk i_dxlate_chk (.*);

  task automatic defaults();
    va = 64'd0; sz = 2'd0; is_store = 0; phys_req = 0; alt_req = 0; ptab_req = 0;
    cur_mode = 2'd0; alt_mode = 2'd0; pal_mode = 0; tlb_hit = 1; tlb_ppn = 32'd0;
    tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_for = 0; tlb_fow = 0;
  endtask

  task automatic issue(input logic [43:0] epa, input logic eunc, input logic [2:0] ef,
                       input logic [5:0] est, input string tag);
    exp_t e;
    e.pa = epa; e.unc = eunc; e.f = ef; e.st = est; e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    defaults();
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1: response with no request, actual fault=%0d expected none", fault);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (pa !== e.pa || uncached !== e.unc || fault !== e.f || mm_stat !== e.st) begin
          n_fail++;
          $display("FAIL %s: actual pa=%h unc=%b fault=%0d stat=%b expected pa=%h unc=%b fault=%0d stat=%b",
                   e.tag, pa, uncached, fault, mm_stat, e.pa, e.unc, e.f, e.st);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || pa !== 0 || fault !== 0 || mm_stat !== 0 || uncached !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: actual v=%b pa=%h f=%0d expected all zero", rsp_valid, pa, fault);
    end
    rst_n = 1'b1;
    defaults();

    // R8 hit load
    va = 64'h0000_0001_2345_6ABC; sz = 2'd2; tlb_ppn = 32'h1234;
    issue(44'h246_8ABC, 0, 3'd0, 6'h00, "R8 hit load");
    // R2 misaligned store
    va = 64'h0000_0001_2345_6ABC; sz = 2'd3; is_store = 1;
    issue(44'd0, 0, 3'd1, 6'h01, "R2 align store");
    // R2 misaligned load beats phys and PAL
    va = 64'h1001; sz = 2'd1; phys_req = 1; pal_mode = 1;
    issue(44'd0, 0, 3'd1, 6'h00, "R2 align load first");
    // R3 physical pass-through, miss and no permission ignored
    va = 64'h0000_0123_4567_89A8; phys_req = 1; tlb_hit = 0; tlb_rd_en = 4'h0;
    issue(44'h123_4567_89A8, 0, 3'd0, 6'h00, "R3 phys");
    // R3 R11 phys with high bit: machine check, no canonical check
    va = 64'h8000_0000_0000_0000; phys_req = 1;
    issue(44'd0, 0, 3'd6, 6'h00, "R3 R11 phys mcheck");
    // R4 non-canonical store
    va = 64'h0001_0000_0000_0000; is_store = 1;
    issue(44'd0, 0, 3'd3, 6'h23, "R4 bad va");
    // R5 superpage kernel, bit40 clear, miss ignored
    va = 64'hFFFF_FC12_3456_7000; sz = 2'd3; tlb_hit = 0;
    issue(44'h012_3456_7000, 0, 3'd0, 6'h00, "R5 superpage low");
    // R5 R12 superpage bit40 set
    va = 64'hFFFF_FD00_0000_2000;
    issue(44'h800_0000_2000, 1, 3'd0, 6'h00, "R5 R12 superpage high");
    // R5 superpage user mode store even in PAL code
    va = 64'hFFFF_FC12_3456_7000; cur_mode = 2'd3; pal_mode = 1; is_store = 1;
    issue(44'd0, 0, 3'd2, 6'h03, "R5 superpage user");
    // R7 misses
    va = 64'h4000; tlb_hit = 0;
    issue(44'd0, 0, 3'd4, 6'h10, "R7 miss load");
    va = 64'h4000; tlb_hit = 0; ptab_req = 1; is_store = 1;
    issue(44'd0, 0, 3'd5, 6'h11, "R7 ptab miss store");
    // R9 stores
    va = 64'h4000; is_store = 1; cur_mode = 2'd3; tlb_wr_en = 4'b0111; tlb_fow = 1;
    issue(44'd0, 0, 3'd3, 6'h0B, "R9 store denied fow");
    va = 64'h4000; is_store = 1; cur_mode = 2'd3; tlb_fow = 1;
    issue(44'd0, 0, 3'd3, 6'h09, "R9 store fow");
    // R10 loads
    va = 64'h4000; cur_mode = 2'd2; tlb_rd_en = 4'b1011; tlb_for = 1;
    issue(44'd0, 0, 3'd2, 6'h06, "R10 load denied for");
    va = 64'h4000; tlb_for = 1;
    issue(44'd0, 0, 3'd3, 6'h04, "R10 load for");
    // R6 PAL override
    va = 64'h123; pal_mode = 1; cur_mode = 2'd3; tlb_rd_en = 4'b0001; tlb_ppn = 32'd5;
    issue(44'h000_0000_A123, 0, 3'd0, 6'h00, "R6 pal kernel");
    va = 64'h123; pal_mode = 1; alt_req = 1; alt_mode = 2'd3; tlb_rd_en = 4'b0001;
    issue(44'd0, 0, 3'd2, 6'h02, "R6 pal alt mode");
    va = 64'h123; alt_req = 1; alt_mode = 2'd0; cur_mode = 2'd3; tlb_rd_en = 4'b0001;
    issue(44'd0, 0, 3'd2, 6'h02, "R6 alt ignored outside pal");
    // R11 hit out of range
    va = 64'h10; tlb_ppn = 32'h8000_0000;
    issue(44'd0, 0, 3'd6, 6'h00, "R11 hit mcheck");
    // R12 unimplemented space and uncached via hit
    va = 64'h0; tlb_ppn = 32'h7FFF_FF80;
    issue(44'd0, 0, 3'd7, 6'h00, "R12 unimp space");
    va = 64'h0; tlb_ppn = 32'h4FFF_FFFF;
    issue(44'h807_FFFF_E000, 1, 3'd0, 6'h00, "R12 uncached hit");

    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_valid !== 0 || sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1 idle: actual v=%b pending=%0d expected v=0 pending=0", rsp_valid, sb.size());
    end
    finish_run();
  end
endmodule